// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block is a byte-level master for a serial EEPROM bus that uses one clock line and one shared data line. A processor writes a single control byte, and the block then sends or receives one byte. The control byte chooses the direction, a number of extra clock cycles to run after the byte, whether the master lets go of the data line once a transmit ends, and whether it then waits for the device to report that it is ready. Software builds EEPROM commands, addresses and payloads from a series of these byte operations.

The serial clock comes from the system clock through a divider that sets its half-period. While an operation runs, `busy` is high. When the operation ends, `busy` falls and `done_irq` pulses for one cycle. In the wait-for-ready phase, the master keeps the clock running with the data line released. It finishes only after it samples the device holding that line high on a rising clock edge.

Top module: `e3w_master`

## Requirements
- R1: A `ctl_wr` pulse while `busy` is low starts an operation, and `busy` reads high from the next cycle until that operation completes.
- R2: A transmit (control bit 7 = 0) produces exactly eight rising edges on `sclk`. `tx_byte` is presented most significant bit first, one bit per rising edge, and `sda_o` changes only while `sclk` is low.
- R3: A receive (control bit 7 = 1) produces eight rising edges on `sclk` and samples `sda_i` on each one, most significant bit first. `sda_oe` stays low for the whole operation, and `rx_byte` holds the received byte once `busy` falls.
- R4: Control bits 3:0 give a count of 0 to 15 extra `sclk` cycles that follow the eight data cycles, in both directions.
- R5: When control bit 6 (release) is set on a transmit, `sda_oe` goes low at the end of the operation. When it is clear, `sda_oe` stays high and `sda_o` keeps the last data bit after completion.
- R6: When a transmit has both bit 6 and bit 5 (wait) set, the master keeps clocking after the extra cycles. It completes on the falling `sclk` edge that follows the first rising edge at which `sda_i` is high. Bit 5 has no effect on a receive or when bit 6 is clear.
- R7: `done_irq` is a one-cycle pulse. It is high in exactly the cycle in which `busy` falls, and it occurs exactly once per operation.
- R8: A `ctl_wr` pulse while `busy` is high is ignored: the running operation's clock count, data and line control are unchanged.
- R9: `sclk` stays high for `HALF_DIV` system cycles per pulse and is low whenever `busy` is low.
- R10: After reset, `busy`, `done_irq`, `sclk` and `sda_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Strobe that writes the control byte |
| ctl_byte | input | 8 | Control byte: bit 7 receive, bit 6 release, bit 5 wait, bits 3:0 extra-clock count |
| tx_byte | input | 8 | Byte to transmit, sampled with `ctl_wr` |
| rx_byte | output | 8 | Last received byte |
| busy | output | 1 | Operation in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock to the device |
| sda_o | output | 1 | Data line output value |
| sda_oe | output | 1 | Data line output enable (high = master drives) |
| sda_i | input | 1 | Data line input value |

## Verification
A wrong bit counter or extra-cycle counter shows up as a wrong number of `sclk` rising edges within one operation. A broken shift path shows up as a wrong byte seen at the rising edges or in `rx_byte` as soon as `busy` falls. An error in the line-release or wait logic shows up at the end of the first affected operation: `sda_oe` is in the wrong state, completion comes too early or never comes, or the interrupt is missing or lasts more than one cycle. A control write that leaks through while busy changes the edge count or the line direction of the running byte.

// File: rtl/e3w_pkg.sv
package e3w_pkg;
  localparam int CNT_W   = 4;
  localparam int RD_BIT  = 7;
  localparam int REL_BIT = 6;
  localparam int WAIT_BIT = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_EXTRA,
    ST_WAIT
  } e3w_state_t;

  typedef struct packed {
    logic             rd;
    logic             rel;
    logic             wfr;
    logic [CNT_W-1:0] cnt;
  } e3w_cfg_t;

  function automatic e3w_cfg_t e3w_decode(input logic [7:0] b);
    e3w_cfg_t c;
    c.rd  = b[RD_BIT];
    c.rel = b[REL_BIT];
    c.wfr = b[WAIT_BIT];
    c.cnt = b[CNT_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/e3w_clkgen.sv
module e3w_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(HALF_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/e3w_shifter.sv
module e3w_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              capture,
  input  logic              sin,
  input  logic              commit,
  output logic              sout,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '1;
      rx_data <= '0;
    end else begin
      if (load)
        sreg <= load_val;
      else if (shift)
        sreg <= {sreg[DATA_W-2:0], 1'b1};
      else if (capture)
        sreg <= {sreg[DATA_W-2:0], sin};
      if (commit)
        rx_data <= sreg;
    end
  end

  assign sout = sreg[DATA_W-1];
endmodule

// File: rtl/e3w_seq.sv
module e3w_seq
  import e3w_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  e3w_cfg_t cfg,
  input  logic     tick,
  input  logic     sda_i,
  output logic     busy,
  output logic     irq,
  output logic     sclk,
  output logic     oe,
  output logic     rd_mode,
  output logic     load,
  output logic     shift,
  output logic     capture,
  output logic     commit
);
  localparam int BC_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  e3w_state_t       st;
  e3w_cfg_t         op;
  logic [BC_W-1:0]  bitcnt;
  logic [CNT_W-1:0] xcnt;
  logic             rdy_seen;

  logic rise, fall, data_end, extra_end, to_post, do_wait, finish;

  always_comb begin
    rise      = tick && !sclk && (st != ST_IDLE);
    fall      = tick &&  sclk && (st != ST_IDLE);
    data_end  = fall && (st == ST_DATA) && (bitcnt == '0);
    extra_end = fall && (st == ST_EXTRA) && (xcnt == CNT_W'(1));
    to_post   = (data_end && (op.cnt == '0)) || extra_end;
    do_wait   = to_post && !op.rd && op.rel && op.wfr;
    finish    = (to_post && !do_wait) || (fall && (st == ST_WAIT) && rdy_seen);
    load      = start;
    shift     = fall && (st == ST_DATA) && (bitcnt != '0) && !op.rd;
    capture   = rise && (st == ST_DATA) && op.rd;
    commit    = finish && op.rd;
    rd_mode   = op.rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op       <= '0;
      bitcnt   <= '0;
      xcnt     <= '0;
      rdy_seen <= 1'b0;
      busy     <= 1'b0;
      irq      <= 1'b0;
      sclk     <= 1'b0;
      oe       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        op       <= cfg;
        st       <= ST_DATA;
        busy     <= 1'b1;
        sclk     <= 1'b0;
        bitcnt   <= BC_W'(DATA_W - 1);
        xcnt     <= cfg.cnt;
        oe       <= !cfg.rd;
        rdy_seen <= 1'b0;
      end else begin
        if (rise) begin
          sclk <= 1'b1;
          if (st == ST_WAIT)
            rdy_seen <= sda_i;
        end
        if (fall)
          sclk <= 1'b0;
        if (fall && (st == ST_DATA) && (bitcnt != '0))
          bitcnt <= bitcnt - 1'b1;
        if (data_end && (op.cnt != '0))
          st <= ST_EXTRA;
        if (fall && (st == ST_EXTRA) && !extra_end)
          xcnt <= xcnt - 1'b1;
        if (to_post && !op.rd && op.rel)
          oe <= 1'b0;
        if (do_wait)
          st <= ST_WAIT;
        if (finish) begin
          st   <= ST_IDLE;
          busy <= 1'b0;
          irq  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/e3w_master.sv
module e3w_master
  import e3w_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_byte,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              done_irq,
  output logic              sclk,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic              sda_i
);
  logic     tick, start, load, shift, capture, commit, sout, rd_mode;
  e3w_cfg_t cfg;

  assign cfg   = e3w_decode(ctl_byte);
  assign start = ctl_wr && !busy;

  e3w_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  e3w_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .tick(tick),
    .sda_i(sda_i), .busy(busy), .irq(done_irq), .sclk(sclk), .oe(sda_oe),
    .rd_mode(rd_mode), .load(load), .shift(shift), .capture(capture),
    .commit(commit)
  );

  e3w_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst(rst), .load(load), .load_val(tx_byte), .shift(shift),
    .capture(capture), .sin(sda_i), .commit(commit), .sout(sout),
    .rx_data(rx_byte)
  );

  assign sda_o = sout | ~sda_oe | rd_mode;
endmodule

// File: rtl/e3w_master_chk.sv
module e3w_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [7:0] ctl_byte,
  input logic       busy,
  input logic       done_irq,
  input logic       sclk,
  input logic       sda_o,
  input logic       sda_oe
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= 1'b0;
    else if (ctl_wr && !busy)
      rd_q <= ctl_byte[7];
  end

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctl_wr));

  // R7
  irq_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_irq);

  // R7
  irq_only_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $fell(busy));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R2
  data_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_o) |-> !sclk);

  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q) |-> !sda_oe);

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
endmodule

bind e3w_master e3w_master_chk u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte), .busy(busy),
  .done_irq(done_irq), .sclk(sclk), .sda_o(sda_o), .sda_oe(sda_oe)
);

// File: tb/test_e3w_master.sv
module test_e3w_master;
  localparam int HALF_DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_byte = '0;
  logic [7:0] tx_byte = '0;
  logic [7:0] rx_byte;
  logic       busy, done_irq, sclk, sda_o, sda_oe;
  logic       sda_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side observation
  logic       sclk_q = 1'b0;
  int         rises = 0;
  int         irq_seen = 0;
  int         cur_hi = 0;
  int         hi_first = 0;
  logic [7:0] wcap = '0;
  bit         oe_any = 0;
  bit         dev_read = 0;
  bit         dev_wait = 0;
  logic [7:0] rd_pat = '0;
  int         ready_after = 0;

  always #5 clk = ~clk;

  e3w_master #(.HALF_DIV(HALF_DIV), .DATA_W(8)) i_e3w_master (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy), .done_irq(done_irq),
    .sclk(sclk), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  always @(negedge clk) begin
    if (sclk && !sclk_q) begin
      rises = rises + 1;
      if (rises <= 8) wcap = {wcap[6:0], sda_o};
    end
    if (sclk) cur_hi = cur_hi + 1;
    else if (sclk_q) begin
      if (hi_first == 0) hi_first = cur_hi;
      cur_hi = 0;
    end
    if (done_irq) irq_seen = irq_seen + 1;
    if (busy && sda_oe) oe_any = 1;
    sclk_q = sclk;
    if (dev_read) sda_i = (rises < 8) ? rd_pat[3'(7 - rises)] : 1'b1;
    else if (dev_wait) sda_i = (rises >= ready_after);
    else sda_i = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; irq_seen = 0; cur_hi = 0; hi_first = 0; wcap = '0; oe_any = 0;
  endtask

  // start one operation and wait for it to end; optional write while busy
  task automatic run_op(input logic [7:0] c, input logic [7:0] tx,
                        input bit disturb);
    int n;
    @(negedge clk); #1;
    clear_mon();
    ctl_byte = c; tx_byte = tx; ctl_wr = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R1", "busy after control write", busy, 1);
    #1 ctl_wr = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk); #1;
      n++;
      if (disturb && n == 20) begin
        ctl_byte = 8'h8F; tx_byte = 8'h00; ctl_wr = 1'b1;
      end else ctl_wr = 1'b0;
    end
    ctl_wr = 1'b0;
    chk(!busy, "R1", "operation completes", busy, 0);
    @(negedge clk); #1;
    chk(irq_seen == 1, "R7", "one completion pulse", irq_seen, 1);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done_irq === 1'b0, "R10", "busy/irq at reset", busy, 0);
    chk(sclk === 1'b0, "R10", "sclk at reset", sclk, 0);
    chk(sda_oe === 1'b0, "R10", "sda_oe at reset", sda_oe, 0);
  endtask

  task automatic t_write_plain();
    run_op(8'h00, 8'hA5, 0);
    chk(rises == 8, "R2", "write clock count", rises, 8);
    chk(wcap == 8'hA5, "R2", "write bits", wcap, 8'hA5);
    chk(sda_oe === 1'b1, "R5", "line kept driven", sda_oe, 1);
    chk(sda_o === 1'b1, "R5", "last bit held", sda_o, 1);
    chk(hi_first == HALF_DIV, "R9", "sclk high width", hi_first, HALF_DIV);
    chk(sclk === 1'b0, "R9", "sclk idle low", sclk, 0);
  endtask

  task automatic t_write_rel();
    run_op(8'h46, 8'h3C, 0);
    chk(rises == 14, "R4", "write + 6 extra clocks", rises, 14);
    chk(wcap == 8'h3C, "R2", "write bits", wcap, 8'h3C);
    chk(sda_oe === 1'b0, "R5", "line released", sda_oe, 0);
  endtask

  task automatic t_read(input logic [7:0] pat, input int cnt);
    rd_pat = pat; dev_read = 1;
    run_op(8'h80 | 8'(cnt), 8'hFF, 0);
    dev_read = 0;
    chk(rises == 8 + cnt, "R4", "read clock count", rises, 8 + cnt);
    chk(rx_byte == pat, "R3", "received byte", rx_byte, pat);
    chk(oe_any == 0, "R3", "no drive during read", oe_any, 0);
  endtask

  task automatic t_wait(input int cnt, input int extra);
    ready_after = 8 + cnt + extra; dev_wait = 1;
    run_op(8'h60 | 8'(cnt), 8'h5A, 0);
    dev_wait = 0;
    chk(rises == ready_after + 1, "R6", "wait ends on ready", rises, ready_after + 1);
    chk(wcap == 8'h5A, "R2", "write bits before wait", wcap, 8'h5A);
    chk(sda_oe === 1'b0, "R6", "line released in wait", sda_oe, 0);
  endtask

  task automatic t_wait_ignored();
    ready_after = 1000; dev_wait = 1;
    run_op(8'h23, 8'hC3, 0);
    dev_wait = 0;
    chk(rises == 11, "R6", "wait ignored without release", rises, 11);
    chk(sda_oe === 1'b1, "R5", "line kept driven", sda_oe, 1);
  endtask

  task automatic t_busy_write();
    run_op(8'h00, 8'h81, 1);
    chk(rises == 8, "R8", "ignored write keeps count", rises, 8);
    chk(wcap == 8'h81, "R8", "ignored write keeps data", wcap, 8'h81);
    chk(oe_any == 1 && sda_oe === 1'b1, "R8", "ignored write keeps drive", sda_oe, 1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_plain();
    t_write_rel();
    t_read(8'h96, 0);
    t_read(8'h3B, 15);
    t_wait(2, 3);
    t_wait(0, 0);
    t_wait_ignored();
    t_busy_write();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule